// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block steps a small stored-program datapath through one instruction at a time on a fixed schedule. Each instruction takes four fetch cycles, one decode cycle and a parameterised number of execute cycles (two by default, seven cycles in all). The four fetch cycles run in this order: address out, memory read, capture into the data register, then transfer to the instruction register together with the program counter bump. The block includes the model datapath: a program counter, an address register, a data register, an instruction register and a synchronous single-clock memory. The memory has a separate write port for loading the program.

The block emits registered control strobes for each step. Other logic uses them to drive the ALU, and to learn when an instruction is decoded and when a halt is flagged. After the last execute cycle, the sequencer does one of three things. It halts for good if decode flagged a halt. It inserts an interrupt check cycle if interrupts are enabled. Otherwise it goes straight to the next fetch. A pending interrupt in the check cycle raises a one-cycle service request, and the sequencer then idles until the service logic reports completion.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, the block is in fetch step one (mar_ld=1, mem_rd=1, every other strobe 0), with pc=0 and addr_bus=0.
- R2: In fetch step one, mar_ld and mem_rd are both 1 and addr_bus equals the current pc. The address register is loaded from pc on every entry to this step.
- R3: In fetch step two, every strobe is 0 and data_bus carries the memory word stored at the address presented in step one.
- R4: In fetch step three, only mdr_ld is 1. From the next cycle on, mdr holds the word that data_bus carried.
- R5: In fetch step four, only ir_ld and pc_inc are 1. On the next cycle, ir equals the previous mdr and pc equals the old pc plus one, modulo 2^AW.
- R6: Decode lasts one cycle with only dec_stb set. dec_halt is sampled only in that cycle, and its value in any other cycle has no effect.
- R7: Execute cycles follow decode, with exe_en bit i set alone in the i-th of them (bit 0 first). With irq_en low in the last execute cycle, the next cycle is fetch step one, whatever the state of irq_pend.
- R8: With irq_en high in the last execute cycle and no halt pending, the next cycle is an interrupt check (only irq_chk set). If irq_pend is low in that cycle, fetch step one follows.
- R9: If irq_pend is high during the check cycle, svc_req is 1 for exactly one cycle. All strobes then stay 0 until a cycle with svc_done high, and fetch step one follows that cycle.
- R10: If dec_halt was high during decode, the cycle after the last execute cycle enters the halted state. In that state only halted is 1, pc stays constant, and all inputs are ignored until reset.
- R11: At most one of mar_ld, mdr_ld, ir_ld, dec_stb, the exe_en bits, irq_chk, svc_req and halted is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | AW | Program memory write address |
| prog_data | input | DW | Program memory write data |
| dec_halt | input | 1 | Halt flag from decode, sampled in the decode cycle |
| irq_en | input | 1 | Interrupt enable, sampled in the last execute cycle |
| irq_pend | input | 1 | Interrupt pending, sampled in the check cycle |
| svc_done | input | 1 | Interrupt service finished, sampled while waiting |
| addr_bus | output | AW | Address bus, driven by the address register |
| data_bus | output | DW | Data bus, driven by the memory read register |
| pc | output | AW | Program counter |
| mdr | output | DW | Memory data register |
| ir | output | DW | Instruction register |
| mar_ld | output | 1 | Fetch step one: address register freshly loaded |
| mem_rd | output | 1 | Memory read strobe (fetch step one) |
| mdr_ld | output | 1 | Fetch step three: data register captures the bus |
| ir_ld | output | 1 | Fetch step four: instruction register load |
| pc_inc | output | 1 | Fetch step four: program counter increment |
| dec_stb | output | 1 | Decode cycle |
| exe_en | output | EXEC_CYCLES | One bit per execute cycle |
| irq_chk | output | 1 | Interrupt check cycle |
| svc_req | output | 1 | One-cycle interrupt service request |
| halted | output | 1 | Sequencer parked until reset |

## Verification
The assertions assume that the memory contents do not change between a read and the capture two cycles later. They also assume that a data bus value is valid to compare only once a read has completed, so that nothing checks the read register before the first fetch. The stimulus loads the whole memory while reset is held and never writes it again afterwards. The stimulus changes dec_halt, irq_en, irq_pend and svc_done only on falling edges. It also holds dec_halt and irq_pend at misleading values in cycles where they must be ignored, so the sampling windows are exercised without violating any of those assumptions.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // One-hot state bit positions of the sequencer (execute steps kept apart)
  localparam int S_T1   = 0;
  localparam int S_T2   = 1;
  localparam int S_T3   = 2;
  localparam int S_T4   = 3;
  localparam int S_DEC  = 4;
  localparam int S_CHK  = 5;
  localparam int S_SVC  = 6;
  localparam int S_WAIT = 7;
  localparam int S_HALT = 8;
  localparam int NSTATE = 9;
endpackage

// File: rtl/seq_mem.sv
module seq_mem #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ram [DEPTH];

  // single clock, one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    if (re) q <= ram[raddr];
  end
endmodule

// File: rtl/seq_regs.sv
module seq_regs #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mar_take,
  input  logic          mdr_take,
  input  logic          ir_take,
  input  logic          pc_step,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mdr,
  output logic [DW-1:0] ir
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
    end else begin
      if (mar_take) mar <= pc;
      if (mdr_take) mdr <= bus_in;
      if (ir_take)  ir  <= mdr;
      if (pc_step)  pc  <= pc + AW'(1);
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int EXEC_CYCLES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dec_halt,
  input  logic                   irq_en,
  input  logic                   irq_pend,
  input  logic                   svc_done,
  output logic [NSTATE-1:0]      st,
  output logic [EXEC_CYCLES-1:0] ex,
  output logic                   fetch_next
);
  logic [NSTATE-1:0]      st_nxt;
  logic [EXEC_CYCLES-1:0] ex_nxt;
  logic                   halt_q;
  logic                   ex_last;

  assign ex_last = ex[EXEC_CYCLES-1];

  // execute steps form a shift chain fed by the decode step
  generate
    if (EXEC_CYCLES == 1) begin : g_ex_one
      assign ex_nxt = st[S_DEC];
    end else begin : g_ex_chain
      assign ex_nxt = {ex[EXEC_CYCLES-2:0], st[S_DEC]};
    end
  endgenerate

  always_comb begin
    st_nxt         = '0;
    st_nxt[S_T2]   = st[S_T1];
    st_nxt[S_T3]   = st[S_T2];
    st_nxt[S_T4]   = st[S_T3];
    st_nxt[S_DEC]  = st[S_T4];
    st_nxt[S_HALT] = st[S_HALT] | (ex_last & halt_q);
    st_nxt[S_CHK]  = ex_last & ~halt_q & irq_en;
    st_nxt[S_SVC]  = st[S_CHK] & irq_pend;
    st_nxt[S_WAIT] = st[S_SVC] | (st[S_WAIT] & ~svc_done);
    st_nxt[S_T1]   = (ex_last & ~halt_q & ~irq_en)
                   | (st[S_CHK] & ~irq_pend)
                   | (st[S_WAIT] & svc_done);
  end

  assign fetch_next = st_nxt[S_T1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= NSTATE'(1) << S_T1;
      ex     <= '0;
      halt_q <= 1'b0;
    end else begin
      st <= st_nxt;
      ex <= ex_nxt;
      if (st[S_DEC]) halt_q <= dec_halt;
    end
  end
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import seq_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int EXEC_CYCLES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   prog_we,
  input  logic [AW-1:0]          prog_addr,
  input  logic [DW-1:0]          prog_data,
  input  logic                   dec_halt,
  input  logic                   irq_en,
  input  logic                   irq_pend,
  input  logic                   svc_done,
  output logic [AW-1:0]          addr_bus,
  output logic [DW-1:0]          data_bus,
  output logic [AW-1:0]          pc,
  output logic [DW-1:0]          mdr,
  output logic [DW-1:0]          ir,
  output logic                   mar_ld,
  output logic                   mem_rd,
  output logic                   mdr_ld,
  output logic                   ir_ld,
  output logic                   pc_inc,
  output logic                   dec_stb,
  output logic [EXEC_CYCLES-1:0] exe_en,
  output logic                   irq_chk,
  output logic                   svc_req,
  output logic                   halted
);
  logic [NSTATE-1:0]      st;
  logic [EXEC_CYCLES-1:0] ex;
  logic                   fetch_next;
  logic [AW-1:0]          mar;

  seq_ctrl #(.EXEC_CYCLES(EXEC_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .dec_halt(dec_halt), .irq_en(irq_en),
    .irq_pend(irq_pend), .svc_done(svc_done),
    .st(st), .ex(ex), .fetch_next(fetch_next)
  );

  seq_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .mar_take(fetch_next), .mdr_take(st[S_T3]),
    .ir_take(st[S_T4]), .pc_step(st[S_T4]), .bus_in(data_bus),
    .pc(pc), .mar(mar), .mdr(mdr), .ir(ir)
  );

  seq_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
    .re(st[S_T1]), .raddr(mar), .q(data_bus)
  );

  // strobes are the registered state bits themselves
  assign addr_bus = mar;
  assign mar_ld   = st[S_T1];
  assign mem_rd   = st[S_T1];
  assign mdr_ld   = st[S_T3];
  assign ir_ld    = st[S_T4];
  assign pc_inc   = st[S_T4];
  assign dec_stb  = st[S_DEC];
  assign exe_en   = ex;
  assign irq_chk  = st[S_CHK];
  assign svc_req  = st[S_SVC];
  assign halted   = st[S_HALT];
endmodule

// File: rtl/instr_cycle_seq_chk.sv
module instr_cycle_seq_chk #(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int EXEC_CYCLES = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic [AW-1:0]          addr_bus,
  input logic [DW-1:0]          data_bus,
  input logic [AW-1:0]          pc,
  input logic [DW-1:0]          mdr,
  input logic [DW-1:0]          ir,
  input logic                   mar_ld,
  input logic                   mdr_ld,
  input logic                   ir_ld,
  input logic                   dec_stb,
  input logic [EXEC_CYCLES-1:0] exe_en,
  input logic                   irq_chk,
  input logic                   svc_req,
  input logic                   halted
);
  assert_addr_is_pc_R2: assert property (@(posedge clk) disable iff (rst)
    mar_ld |-> addr_bus == pc);

  assert_mdr_capture_R4: assert property (@(posedge clk) disable iff (rst)
    mdr_ld |=> mdr == $past(data_bus));

  assert_ir_pc_update_R5: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> (ir == $past(mdr)) && (pc == AW'($past(pc) + 1)));

  assert_decode_to_exec_R6: assert property (@(posedge clk) disable iff (rst)
    dec_stb |=> exe_en[0]);

  assert_load_to_decode_R7: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> dec_stb);

  assert_check_after_exec_R8: assert property (@(posedge clk) disable iff (rst)
    irq_chk |-> $past(exe_en[EXEC_CYCLES-1]));

  assert_svc_single_R9: assert property (@(posedge clk) disable iff (rst)
    svc_req |=> !svc_req);

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc));

  assert_one_step_R11: assert property (@(posedge clk) disable iff (rst)
    $countones({mar_ld, mdr_ld, ir_ld, dec_stb, exe_en, irq_chk, svc_req, halted}) <= 1);
endmodule

bind instr_cycle_seq instr_cycle_seq_chk #(
  .AW(AW), .DW(DW), .EXEC_CYCLES(EXEC_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .addr_bus(addr_bus), .data_bus(data_bus), .pc(pc),
  .mdr(mdr), .ir(ir), .mar_ld(mar_ld), .mdr_ld(mdr_ld), .ir_ld(ir_ld),
  .dec_stb(dec_stb), .exe_en(exe_en), .irq_chk(irq_chk), .svc_req(svc_req),
  .halted(halted)
);

// File: tb/instr_cycle_seq_test.sv
module instr_cycle_seq_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int EX = 2;
  localparam int DEPTH = 1 << AW;

  // strobe vector {mar_ld,mem_rd,mdr_ld,ir_ld,pc_inc,dec_stb,exe_en[1:0],irq_chk,svc_req,halted}
  localparam logic [10:0] SB_T1   = 11'b11000000000;
  localparam logic [10:0] SB_NONE = 11'b00000000000;
  localparam logic [10:0] SB_T3   = 11'b00100000000;
  localparam logic [10:0] SB_T4   = 11'b00011000000;
  localparam logic [10:0] SB_DEC  = 11'b00000100000;
  localparam logic [10:0] SB_E1   = 11'b00000001000;
  localparam logic [10:0] SB_E2   = 11'b00000010000;
  localparam logic [10:0] SB_CHK  = 11'b00000000100;
  localparam logic [10:0] SB_SVC  = 11'b00000000010;
  localparam logic [10:0] SB_HALT = 11'b00000000001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_we = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [DW-1:0] prog_data = '0;
  logic dec_halt = 1'b0, irq_en = 1'b0, irq_pend = 1'b0, svc_done = 1'b0;
  logic [AW-1:0] addr_bus, pc;
  logic [DW-1:0] data_bus, mdr, ir;
  logic mar_ld, mem_rd, mdr_ld, ir_ld, pc_inc, dec_stb, irq_chk, svc_req, halted;
  logic [EX-1:0] exe_en;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  instr_cycle_seq #(.AW(AW), .DW(DW), .EXEC_CYCLES(EX)) uut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .dec_halt(dec_halt), .irq_en(irq_en),
    .irq_pend(irq_pend), .svc_done(svc_done), .addr_bus(addr_bus),
    .data_bus(data_bus), .pc(pc), .mdr(mdr), .ir(ir), .mar_ld(mar_ld),
    .mem_rd(mem_rd), .mdr_ld(mdr_ld), .ir_ld(ir_ld), .pc_inc(pc_inc),
    .dec_stb(dec_stb), .exe_en(exe_en), .irq_chk(irq_chk),
    .svc_req(svc_req), .halted(halted)
  );

  function automatic logic [DW-1:0] word_at(input int a);
    return DW'(a * 40503) ^ 16'hA5C3;
  endfunction

  function automatic logic [10:0] strobes();
    return {mar_ld, mem_rd, mdr_ld, ir_ld, pc_inc, dec_stb, exe_en, irq_chk, svc_req, halted};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_sb(input logic [10:0] exp, input string req);
    check(strobes() === exp, req, "strobes", 32'(strobes()), 32'(exp));
  endtask

  // starts and ends at a falling edge inside fetch step one
  task automatic do_instr(input int a, input bit ien, input bit pend,
                          input bit hlt, input int dly);
    logic [AW-1:0] nxt;
    nxt = AW'(a + 1);
    irq_en = 1'b0; irq_pend = 1'b0; svc_done = 1'b0; dec_halt = 1'b0;
    check_sb(SB_T1, "R2");
    check(addr_bus === AW'(a), "R2", "addr_bus", 32'(addr_bus), 32'(a));
    @(negedge clk);
    check_sb(SB_NONE, "R3");
    check(data_bus === word_at(a), "R3", "data_bus", 32'(data_bus), 32'(word_at(a)));
    @(negedge clk);
    check_sb(SB_T3, "R4");
    @(negedge clk);
    check_sb(SB_T4, "R5");
    check(mdr === word_at(a), "R4", "mdr", 32'(mdr), 32'(word_at(a)));
    @(negedge clk);
    check_sb(SB_DEC, "R6");
    check(ir === word_at(a), "R5", "ir", 32'(ir), 32'(word_at(a)));
    check(pc === nxt, "R5", "pc", 32'(pc), 32'(nxt));
    dec_halt = hlt;
    @(negedge clk);
    check_sb(SB_E1, "R7");
    dec_halt = ~hlt;  // outside decode: must be ignored (R6)
    @(negedge clk);
    check_sb(SB_E2, "R7");
    dec_halt = 1'b0;
    irq_en = ien;
    irq_pend = pend;
    @(negedge clk);
    if (hlt) begin
      check_sb(SB_HALT, "R10");
      for (int i = 0; i < 12; i++) begin
        irq_en = 1'b1; irq_pend = 1'b1; svc_done = i[0]; dec_halt = i[1];
        @(negedge clk);
        check_sb(SB_HALT, "R10");
        check(pc === nxt, "R10", "pc", 32'(pc), 32'(nxt));
      end
    end else if (ien) begin
      check_sb(SB_CHK, "R8");
      irq_en = 1'b0;
      irq_pend = pend;
      @(negedge clk);
      if (pend) begin
        check_sb(SB_SVC, "R9");
        irq_pend = 1'b0;
        for (int d = 0; d <= dly; d++) begin
          @(negedge clk);
          check_sb(SB_NONE, "R9");
          svc_done = (d == dly);
        end
        @(negedge clk);
        svc_done = 1'b0;
      end
    end
    // non-halt paths now sit in fetch step one; the next call checks it (R7, R8, R9)
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = AW'(i); prog_data = word_at(i);
    end
    @(negedge clk);
    prog_we = 1'b0;
    @(negedge clk);
    check_sb(SB_T1, "R1");
    check(pc === '0, "R1", "pc", 32'(pc), 32'd0);
    check(addr_bus === '0, "R1", "addr_bus", 32'(addr_bus), 32'd0);
    rst = 1'b0;
    // sweep every address, the pc wrap, and the interrupt path variants
    for (int k = 0; k < DEPTH + 4; k++) begin
      bit ien, pend;
      ien  = (k % 3) != 0;
      pend = (k % 4) < 2;
      do_instr(k % DEPTH, ien, pend, k == DEPTH + 3, k % 3);
    end
    // reset leaves the halted state (R1)
    rst = 1'b1;
    @(negedge clk);
    check_sb(SB_T1, "R1");
    check(pc === '0, "R1", "pc", 32'(pc), 32'd0);
    rst = 1'b0;
    do_instr(0, 1'b0, 1'b1, 1'b0, 0);
    do_instr(1, 1'b1, 1'b1, 1'b0, 2);
    check_sb(SB_T1, "R9");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule